// File: doc/BRIEF.md
# Two-Level Write-Through Cache Controller

This block sequences single-word processor accesses across a small level-one store, a larger level-two store and a main-memory port. Both levels are held inside the block as direct-mapped arrays of tag, data and valid bits. Every write goes through to memory, so the memory always holds the newest copy of every word and the caches never need to write anything back on replacement.

A read is served from level one when the word is present there. Otherwise level two is tried one cycle later. If level two also misses, a memory read is issued and the returned word is installed in both levels. A write first looks in level one. If the word is present and already holds the write value, the access completes at once and nothing is written anywhere. In every other case one memory write is issued and the word is installed or updated in both cache levels when it completes.

The processor holds its request until `cpuDone` is high in a cycle. `cpuDone` is combinational, so a level-one read hit completes in the cycle the request is first seen. Per-level hit flags accompany `cpuDone` so a checker can tell which level served each access.

Top module: `wt_cache_ctrl`

## Requirements
- R1: After reset every line of both levels is invalid, so the first access to any word reaches memory. While idle after reset, `cpuDone`, `memReq`, `l1Hit` and `l2Hit` are low.
- R2: A read whose word is in level one completes in the first cycle the request is seen. `l1Hit` is high, the stored word is returned and no memory transaction occurs.
- R3: A read that misses level one but hits level two completes in its second cycle with `l2Hit` high and no memory transaction. The word is also copied into level one.
- R4: A read that misses both levels issues one memory read with `memWe` low and `memAddr` equal to `cpuAddr` without its offset bits. It completes in the cycle `memReady` is seen, returns `memRdata`, and both hit flags are low.
- R5: A word fetched from memory is installed in level two and in level one. Both levels are direct mapped: the level-one slot is word-address bits [L1_IDX_W-1:0] and the level-two slot is word-address bits [L2_IDX_W-1:0], with the remaining upper bits kept as the tag. A newly installed word replaces whatever the slot held.
- R6: A write whose word is in level one and already holds the write data completes in the first cycle with `l1Hit` high and no memory transaction.
- R7: A write whose word is in level one with different data issues exactly one memory write of the new data and completes with `l1Hit` high. Afterwards both levels return the new data.
- R8: A write whose word is absent from level one issues exactly one memory write and completes with both hit flags low. The word is then present in level one and level two with the written data.
- R9: The lowest OFF_W address bits are ignored. Addresses that differ only there refer to the same word.
- R10: While `memReq` is high and `memReady` is low, `memReq`, `memAddr`, `memWe` and `memWdata` hold their values into the next cycle and `cpuDone` stays low. The processor keeps its request inputs stable until `cpuDone`.
- R11: At most one of `l1Hit` and `l2Hit` is high, and neither is high without `cpuDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | Processor request, held until done |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Byte address: tag, index, offset |
| cpuWdata | input | DATA_W | Write data |
| cpuDone | output | 1 | Access completes this cycle |
| cpuRdata | output | DATA_W | Read data, valid with cpuDone on reads |
| l1Hit | output | 1 | Access found its word in level one |
| l2Hit | output | 1 | Read served by level two |
| memReq | output | 1 | Memory transaction request |
| memWe | output | 1 | Memory transaction is a write |
| memAddr | output | ADDR_W-OFF_W | Memory word address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, valid with memReady |
| memReady | input | 1 | Memory completes the transaction this cycle |

## Verification
The hardest state to reach from the ports is a read that hits level two. The word must have been displaced from level one while it still survives in level two, which needs a second word that shares the level-one slot but not the level-two slot. The bench sweeps every word address and reads each word, then reads the word four positions away (word address XOR 4), then reads the first word again. A reference model of both tag stores predicts the serving level, the flags, the latency under several memory delays, and the memory contents after every write.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;

  // source of data for cache fills and for the processor read mux
  typedef enum logic [1:0] {
    SRC_L1  = 2'd0,
    SRC_L2  = 2'd1,
    SRC_MEM = 2'd2,
    SRC_CPU = 2'd3
  } srcSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    l1Wr;
    logic    l2Wr;
    srcSel_e src;
  } cacheStrb_t;

endpackage

// File: rtl/wt_cache_level.sv
module wt_cache_level #(
  parameter int WADDR_W = 7,
  parameter int IDX_W   = 2,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WADDR_W-1:0] wordAddr,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic               hit,
  output logic [DATA_W-1:0]  rdData
);
  localparam int TAG_W = WADDR_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;

  logic [SETS-1:0]   validQ;
  logic [TAG_W-1:0]  tagQ  [SETS];
  logic [DATA_W-1:0] dataQ [SETS];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;

  assign idx    = wordAddr[IDX_W-1:0];
  assign tag    = wordAddr[WADDR_W-1:IDX_W];
  assign hit    = validQ[idx] && (tagQ[idx] == tag);
  assign rdData = dataQ[idx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     validQ      <= '0;
    else if (wrEn) validQ[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      tagQ[idx]  <= tag;
      dataQ[idx] <= wrData;
    end
  end

  // R5: a written slot reports a hit for the same word on the next cycle
  a_r5_install_hits: assert property (@(posedge clk) disable iff (!rstN)
    wrEn ##1 (wordAddr == $past(wordAddr)) |-> hit && (rdData == $past(wrData)));

endmodule

// File: rtl/wt_cache_dp.sv
module wt_cache_dp
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int OFF_W    = 1,
  parameter int L1_IDX_W = 2,
  parameter int L2_IDX_W = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [DATA_W-1:0]       cpuWdata,
  input  logic [DATA_W-1:0]       memRdata,
  input  cacheStrb_t              strb,
  output logic                    l1Match,
  output logic                    l2Match,
  output logic                    dataSame,
  output logic [DATA_W-1:0]       cpuRdata,
  output logic [ADDR_W-OFF_W-1:0] memAddr,
  output logic [DATA_W-1:0]       memWdata
);
  localparam int WADDR_W = ADDR_W - OFF_W;

  logic [WADDR_W-1:0] wordAddr;
  logic [OFF_W-1:0]   unusedOffset;
  logic [DATA_W-1:0]  l1Data, l2Data, fillData;

  assign wordAddr     = cpuAddr[ADDR_W-1:OFF_W];
  assign unusedOffset = cpuAddr[OFF_W-1:0];

  always_comb begin
    unique case (strb.src)
      SRC_L2:  fillData = l2Data;
      SRC_MEM: fillData = memRdata;
      default: fillData = cpuWdata;
    endcase
  end

  always_comb begin
    unique case (strb.src)
      SRC_L1:  cpuRdata = l1Data;
      SRC_L2:  cpuRdata = l2Data;
      SRC_MEM: cpuRdata = memRdata;
      default: cpuRdata = '0;
    endcase
  end

  wt_cache_level #(.WADDR_W(WADDR_W), .IDX_W(L1_IDX_W), .DATA_W(DATA_W)) u_l1 (
    .clk(clk), .rstN(rstN), .wordAddr(wordAddr), .wrEn(strb.l1Wr),
    .wrData(fillData), .hit(l1Match), .rdData(l1Data));

  wt_cache_level #(.WADDR_W(WADDR_W), .IDX_W(L2_IDX_W), .DATA_W(DATA_W)) u_l2 (
    .clk(clk), .rstN(rstN), .wordAddr(wordAddr), .wrEn(strb.l2Wr),
    .wrData(fillData), .hit(l2Match), .rdData(l2Data));

  assign dataSame = (l1Data == cpuWdata);
  assign memAddr  = wordAddr;
  assign memWdata = cpuWdata;

  // R5: a fill from memory always lands in both levels
  a_r5_fill_both: assert property (@(posedge clk) disable iff (!rstN)
    (strb.src == SRC_MEM) && strb.l2Wr |-> strb.l1Wr);
  // R7: a processor write updating level one also updates level two
  a_r7_write_both: assert property (@(posedge clk) disable iff (!rstN)
    strb.l1Wr && (strb.src == SRC_CPU) |-> strb.l2Wr);

endmodule

// File: rtl/wt_cache_fsm.sv
module wt_cache_fsm
  import wt_cache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuWe,
  input  logic       l1Match,
  input  logic       l2Match,
  input  logic       dataSame,
  input  logic       memReady,
  output logic       cpuDone,
  output logic       memReq,
  output logic       memWe,
  output logic       l1Hit,
  output logic       l2Hit,
  output cacheStrb_t strb
);
  typedef enum logic [1:0] {S_IDLE, S_L2RD, S_MEMRD, S_MEMWR} state_e;

  state_e stateQ, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateNxt;
  end

  always_comb begin
    stateNxt  = stateQ;
    cpuDone   = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    strb.l1Wr = 1'b0;
    strb.l2Wr = 1'b0;
    strb.src  = SRC_L1;
    unique case (stateQ)
      S_IDLE: begin
        if (cpuReq) begin
          if (!cpuWe) begin
            if (l1Match) cpuDone  = 1'b1;
            else         stateNxt = S_L2RD;
          end else begin
            if (l1Match && dataSame) cpuDone  = 1'b1;
            else                     stateNxt = S_MEMWR;
          end
        end
      end
      S_L2RD: begin
        strb.src = SRC_L2;
        if (l2Match) begin
          cpuDone   = 1'b1;
          strb.l1Wr = 1'b1;
          stateNxt  = S_IDLE;
        end else begin
          stateNxt  = S_MEMRD;
        end
      end
      S_MEMRD: begin
        memReq   = 1'b1;
        strb.src = SRC_MEM;
        if (memReady) begin
          cpuDone   = 1'b1;
          strb.l1Wr = 1'b1;
          strb.l2Wr = 1'b1;
          stateNxt  = S_IDLE;
        end
      end
      default: begin
        memReq   = 1'b1;
        memWe    = 1'b1;
        strb.src = SRC_CPU;
        if (memReady) begin
          cpuDone   = 1'b1;
          strb.l1Wr = 1'b1;
          strb.l2Wr = 1'b1;
          stateNxt  = S_IDLE;
        end
      end
    endcase
  end

  assign l1Hit = cpuDone && l1Match;
  assign l2Hit = cpuDone && (stateQ == S_L2RD);

  // R6: a write finishing without memory leaves both levels untouched
  a_r6_equal_write_no_update: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone && cpuWe && !memReq |-> !strb.l1Wr && !strb.l2Wr);
  // R3: a level-two hit never touches memory
  a_r3_l2_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    l2Hit |-> !memReq && !cpuWe);
  // R8: a write missing level one completes through a memory write
  a_r8_miss_writes_mem: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone && cpuWe && !l1Hit |-> memReq && memWe && strb.l1Wr && strb.l2Wr);

endmodule

// File: rtl/wt_cache_ctrl.sv
module wt_cache_ctrl
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int OFF_W    = 1,
  parameter int L1_IDX_W = 2,
  parameter int L2_IDX_W = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cpuReq,
  input  logic                    cpuWe,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [DATA_W-1:0]       cpuWdata,
  output logic                    cpuDone,
  output logic [DATA_W-1:0]       cpuRdata,
  output logic                    l1Hit,
  output logic                    l2Hit,
  output logic                    memReq,
  output logic                    memWe,
  output logic [ADDR_W-OFF_W-1:0] memAddr,
  output logic [DATA_W-1:0]       memWdata,
  input  logic [DATA_W-1:0]       memRdata,
  input  logic                    memReady
);
  cacheStrb_t strb;
  logic       l1Match, l2Match, dataSame;

  wt_cache_fsm u_fsm (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .l1Match(l1Match), .l2Match(l2Match), .dataSame(dataSame),
    .memReady(memReady), .cpuDone(cpuDone), .memReq(memReq), .memWe(memWe),
    .l1Hit(l1Hit), .l2Hit(l2Hit), .strb(strb));

  wt_cache_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W),
                .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .memRdata(memRdata), .strb(strb), .l1Match(l1Match), .l2Match(l2Match),
    .dataSame(dataSame), .cpuRdata(cpuRdata), .memAddr(memAddr),
    .memWdata(memWdata));

  // R10: a pending memory transaction holds its request fields
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memWe)
                            && $stable(memWdata));
  // R10: no completion while memory is stalling
  a_r10_no_early_done: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |-> !cpuDone);
  // R11: hit flags are exclusive and only accompany completion
  a_r11_flags: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({l1Hit, l2Hit}) && ((l1Hit || l2Hit) -> cpuDone));
  // R4: a read completing without a cache hit is a memory read
  a_r4_read_from_mem: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone && !cpuWe && !l1Hit && !l2Hit |-> memReq && memReady && !memWe
                                              && (cpuRdata == memRdata));
  // R2: a level-one read hit never touches memory
  a_r2_l1_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone && !cpuWe && l1Hit |-> !memReq);

endmodule

// File: tb/wt_cache_ctrl_test.sv
`timescale 1ns/1ps
module wt_cache_ctrl_test;
  localparam int ADDR_W = 8, DATA_W = 8, OFF_W = 1, L1_IDX_W = 2, L2_IDX_W = 3;
  localparam int WADDR_W = ADDR_W - OFF_W;
  localparam int WORDS = 1 << WADDR_W;
  localparam int L1_SETS = 1 << L1_IDX_W;
  localparam int L2_SETS = 1 << L2_IDX_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic cpuDone, l1Hit, l2Hit, memReq, memWe;
  logic [DATA_W-1:0] cpuRdata, memWdata, memRdata;
  logic [WADDR_W-1:0] memAddr;
  logic memReady = 1'b0;

  always #2 clk = ~clk;

  wt_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W),
                  .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W)) uut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuDone(cpuDone), .cpuRdata(cpuRdata), .l1Hit(l1Hit),
    .l2Hit(l2Hit), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady));

  int nChecks = 0, nFails = 0;

  // memory model with programmable delay
  logic [DATA_W-1:0] mem [WORDS];
  int memLat = 0, waitCnt = 0, memTx = 0;
  assign memRdata = mem[memAddr];

  always @(negedge clk) begin
    if (!memReq) begin
      waitCnt  = 0;
      memReady = 1'b0;
    end else begin
      memReady = (waitCnt >= memLat);
      waitCnt  = waitCnt + 1;
    end
  end

  always @(posedge clk) begin
    if (rstN && memReq && memReady) begin
      memTx = memTx + 1;
      if (memWe) mem[memAddr] <= memWdata;
    end
  end

  // reference model: expected memory contents and both tag stores
  logic [DATA_W-1:0] refMem [WORDS];
  bit m1v [L1_SETS];
  int m1t [L1_SETS];
  bit m2v [L2_SETS];
  int m2t [L2_SETS];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic access(input bit we, input int addr, input int wd,
                        input int lat, input string req);
    int w = addr >> OFF_W;
    int i1 = w % L1_SETS, i2 = w % L2_SETS;
    bit h1 = m1v[i1] && (m1t[i1] == w / L1_SETS);
    bit h2 = m2v[i2] && (m2t[i2] == w / L2_SETS);
    int expCyc, expTx, expData;
    bit expL1, expL2, same, done = 0;
    int cyc = 0, tx0, gotData = 0;
    bit gotL1 = 0, gotL2 = 0;
    if (!we) begin
      expCyc = h1 ? 1 : (h2 ? 2 : 3 + lat);
      expTx = (h1 || h2) ? 0 : 1;
      expL1 = h1; expL2 = !h1 && h2;
      expData = int'(refMem[w]);
      if (!h1) begin m1v[i1] = 1; m1t[i1] = w / L1_SETS; end
      if (!h1 && !h2) begin m2v[i2] = 1; m2t[i2] = w / L2_SETS; end
    end else begin
      same = h1 && (int'(refMem[w]) == wd);
      expCyc = same ? 1 : 2 + lat;
      expTx = same ? 0 : 1;
      expL1 = h1; expL2 = 0; expData = 0;
      if (!same) begin
        refMem[w] = DATA_W'(wd);
        m1v[i1] = 1; m1t[i1] = w / L1_SETS;
        m2v[i2] = 1; m2t[i2] = w / L2_SETS;
      end
    end
    memLat = lat;
    tx0 = memTx;
    cpuReq = 1'b1; cpuWe = we; cpuAddr = ADDR_W'(addr); cpuWdata = DATA_W'(wd);
    while (!done && cyc < 40) begin
      #1;
      cyc++;
      if (cpuDone) begin
        done = 1; gotData = int'(cpuRdata); gotL1 = l1Hit; gotL2 = l2Hit;
      end
      @(negedge clk);
    end
    cpuReq = 1'b0;
    chk(done, req, "completion", int'(done), 1);
    chk(cyc == expCyc, req, "latency cycles", cyc, expCyc);
    chk(gotL1 == expL1, req, "l1Hit", int'(gotL1), int'(expL1));
    chk(gotL2 == expL2, req, "l2Hit", int'(gotL2), int'(expL2));
    chk(!(gotL1 && gotL2), "R11", "both hit flags", 1, 0);
    chk(memTx - tx0 == expTx, req, "memory transactions", memTx - tx0, expTx);
    if (!we) chk(gotData == expData, req, "read data", gotData, expData);
    else     chk(mem[w] == refMem[w], req, "memory word", int'(mem[w]), int'(refMem[w]));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    #(200000 * 4);
    nFails++;
    $display("FAIL watchdog R10: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int w = 0; w < WORDS; w++) begin
      mem[w] = DATA_W'(w * 37 + 11);
      refMem[w] = mem[w];
    end
    for (int i = 0; i < L1_SETS; i++) begin m1v[i] = 0; m1t[i] = 0; end
    for (int i = 0; i < L2_SETS; i++) begin m2v[i] = 0; m2t[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    // R1 and R11: quiet outputs under and after reset
    chk(!cpuDone && !memReq, "R1", "done/memReq in reset", int'(cpuDone || memReq), 0);
    chk(!l1Hit && !l2Hit, "R11", "hit flags in reset", int'(l1Hit || l2Hit), 0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(!cpuDone && !memReq, "R1", "done/memReq idle", int'(cpuDone || memReq), 0);
    @(negedge clk);

    // R1 R4 R10: cold reads of every word with varying memory delay
    for (int w = 0; w < WORDS; w++)
      access(0, w << OFF_W, 0, w % 4, "R1 R4 R10");

    // R2 R3 R5 R9: hit in each level via a conflicting neighbour
    for (int w = 0; w < WORDS; w++) begin
      access(0, (w << OFF_W) | 1, 0, w % 3, "R4 R5 R9");
      access(0, w << OFF_W, 0, 0, "R2 R9");
      access(0, (w ^ 4) << OFF_W, 0, 1, "R4 R5");
      access(0, (w << OFF_W) | 1, 0, 2, "R3 R5");
      access(0, w << OFF_W, 0, 0, "R2");
    end

    // R6 R7 R8: equal, differing and missing writes, then readback
    for (int w = 0; w < WORDS; w++) begin
      access(0, w << OFF_W, 0, 1, "R2 R4");
      access(1, w << OFF_W, int'(refMem[w]), 0, "R6");
      access(1, (w << OFF_W) | 1, int'(refMem[w]) ^ 8'h5A, w % 4, "R7 R9");
      access(0, w << OFF_W, 0, 0, "R7 R2");
      access(0, (w ^ 4) << OFF_W, 0, 0, "R5");
      access(0, w << OFF_W, 0, 0, "R7 R3");
      access(1, (w ^ 8) << OFF_W, (w * 5 + 1) & 8'hFF, w % 3, "R8");
      access(0, (w ^ 8) << OFF_W, 0, 0, "R8 R2");
      access(0, w << OFF_W, 0, 2, "R7 R4");
      access(0, ((w ^ 8) ^ 4) << OFF_W, 0, 0, "R5");
      access(0, (w ^ 8) << OFF_W, 0, 1, "R8 R3 R4");
    end

    summary();
    $finish;
  end
endmodule